// File: doc/BRIEF.md
# Branch Opcode Type Classifier

This block sorts a recorded control-flow transfer into one category. It takes the leading opcode bytes and the ModRM byte of the instruction at the source address. It also takes the privilege level of the source and of the target, and two flags that say whether either address was zero. From these it produces a 12-bit category mask. A trace filter downstream compares this mask against a requested selection and keeps or drops the record. The decode depends only on the opcode; prefixes, instruction length and address checking are left to the logic that feeds it.

The result is registered. One sample is taken per cycle while `valid_i` is high, and the mask for that sample appears on `type_o` on the next clock edge. When `valid_i` is low the last mask is held. Any transfer that goes from user level to kernel level and was not started by a system-call or software-interrupt opcode is counted as an asynchronous event (an interrupt or a fault). If the category is not empty, the target privilege bit is added to it.

Top module: `brtype_classifier`

## Requirements
- R1: During and right after reset, `valid_o` is 0 and `type_o` is 12'h000.
- R2: If `src_zero_i` or `dst_zero_i` is set, the mask is 12'h000, whatever the opcode or privilege.
- R3: When `op0_i` is 8'h0F, `op1_i` decides the category. 05 or 34 gives syscall (bit 4). 07 or 35 gives sysret (bit 5). 80..8F gives conditional (bit 8). Any other value gives no category.
- R4: For other values of `op0_i`: 70..7F and E0..E3 give conditional (bit 8). C2, C3, CA and CB give return (bit 3). CF gives iret (bit 7). CC..CE give software interrupt (bit 6). E8 and 9A give call (bit 2). E9..EB give jump (bit 9). Every other value except FF gives no category.
- R5: When `op0_i` is 8'hFF, `modrm_i[5:3]` decides the category. 2 or 3 gives indirect call (bit 11). 4 or 5 gives jump (bit 9). Any other value gives no category.
- R6: If the source is user level (`src_kernel_i`=0), the target is kernel level (`dst_kernel_i`=1), and neither address is zero, the category is hardware interrupt/fault (bit 10). This replaces any decoded category, including none. The two exceptions are syscall and software interrupt, which are kept.
- R7: A non-empty category also carries exactly one privilege bit. That bit is kernel (bit 1) when `dst_kernel_i`=1 and user (bit 0) otherwise. An empty category gives 12'h000.
- R8: `valid_o` equals `valid_i` delayed by one clock. `type_o` shows the mask of the sample taken one clock earlier. `type_o` does not change in a cycle after `valid_i` was 0.
- R9: At most one of bits 11..2 is set in any mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe |
| op0_i | input | 8 | First opcode byte |
| op1_i | input | 8 | Second opcode byte (used after 0F) |
| modrm_i | input | 8 | ModRM byte (used after FF) |
| src_kernel_i | input | 1 | Source address is kernel level |
| dst_kernel_i | input | 1 | Target address is kernel level |
| src_zero_i | input | 1 | Source address is zero |
| dst_zero_i | input | 1 | Target address is zero |
| valid_o | output | 1 | Mask valid, one cycle after `valid_i` |
| type_o | output | 12 | Category mask |

## Verification
The hardest case to reach is the interaction between the ring-crossing override and the decode. An opcode with no category must still come out as hardware interrupt with the kernel bit, while syscall and software-interrupt opcodes must keep their own category. The bench reaches this by sweeping every first-byte value under all four source/target privilege pairings. It also sweeps every second byte behind 0F and every ModRM extension behind FF, under the same pairings. Zero-address flags and idle cycles with changed inputs are added to cover the override and the hold behaviour.

// File: rtl/brtype_pkg.sv
package brtype_pkg;
  parameter int OPC_W  = 8;
  parameter int MASK_W = 12;
  parameter int EXT_LO = 3;
  parameter int EXT_W  = 3;

  localparam int B_USER    = 0;
  localparam int B_KERNEL  = 1;
  localparam int B_CALL    = 2;
  localparam int B_RET     = 3;
  localparam int B_SYSCALL = 4;
  localparam int B_SYSRET  = 5;
  localparam int B_INT     = 6;
  localparam int B_IRET    = 7;
  localparam int B_JCC     = 8;
  localparam int B_JMP     = 9;
  localparam int B_IRQ     = 10;
  localparam int B_INDCALL = 11;

  typedef logic [MASK_W-1:0] mask_t;

  function automatic mask_t cat(input int b);
    mask_t m;
    m = '0;
    m[b] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/brtype_opdec.sv
module brtype_opdec
  import brtype_pkg::*;
(
  input  logic [OPC_W-1:0] op0_i,
  input  logic [OPC_W-1:0] op1_i,
  input  logic [OPC_W-1:0] modrm_i,
  output mask_t            cat_o
);
  logic [EXT_W-1:0] ext;
  mask_t esc_cat, ff_cat;

  assign ext = modrm_i[EXT_LO +: EXT_W];

  // two-byte escape
  always_comb begin
    unique case (op1_i) inside
      8'h05, 8'h34: esc_cat = cat(B_SYSCALL);
      8'h07, 8'h35: esc_cat = cat(B_SYSRET);
      [8'h80:8'h8F]: esc_cat = cat(B_JCC);
      default:      esc_cat = '0;
    endcase
  end

  // group opcode selected by ModRM reg field
  always_comb begin
    unique case (ext)
      3'd2, 3'd3: ff_cat = cat(B_INDCALL);
      3'd4, 3'd5: ff_cat = cat(B_JMP);
      default:    ff_cat = '0;
    endcase
  end

  always_comb begin
    unique case (op0_i) inside
      8'h0F:                       cat_o = esc_cat;
      8'hFF:                       cat_o = ff_cat;
      [8'h70:8'h7F], [8'hE0:8'hE3]: cat_o = cat(B_JCC);
      8'hC2, 8'hC3, 8'hCA, 8'hCB:  cat_o = cat(B_RET);
      8'hCF:                       cat_o = cat(B_IRET);
      [8'hCC:8'hCE]:               cat_o = cat(B_INT);
      8'hE8, 8'h9A:                cat_o = cat(B_CALL);
      [8'hE9:8'hEB]:               cat_o = cat(B_JMP);
      default:                     cat_o = '0;
    endcase
  end
endmodule

// File: rtl/brtype_plm_adj.sv
module brtype_plm_adj
  import brtype_pkg::*;
(
  input  mask_t cat_i,
  input  logic  src_kernel_i,
  input  logic  dst_kernel_i,
  input  logic  src_zero_i,
  input  logic  dst_zero_i,
  output mask_t mask_o
);
  logic  crossing, keep;
  mask_t adj;

  assign crossing = !src_kernel_i && dst_kernel_i;
  assign keep     = cat_i[B_SYSCALL] || cat_i[B_INT];

  always_comb begin
    adj = (crossing && !keep) ? cat(B_IRQ) : cat_i;
    if (adj != '0) begin
      if (dst_kernel_i) adj[B_KERNEL] = 1'b1;
      else              adj[B_USER]   = 1'b1;
    end
    mask_o = (src_zero_i || dst_zero_i) ? '0 : adj;
  end
endmodule

// File: rtl/brtype_classifier.sv
module brtype_classifier
  import brtype_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OPC_W-1:0]  op0_i,
  input  logic [OPC_W-1:0]  op1_i,
  input  logic [OPC_W-1:0]  modrm_i,
  input  logic              src_kernel_i,
  input  logic              dst_kernel_i,
  input  logic              src_zero_i,
  input  logic              dst_zero_i,
  output logic              valid_o,
  output logic [MASK_W-1:0] type_o
);
  mask_t dec_cat, next_mask;

  brtype_opdec u_opdec (
    .op0_i  (op0_i),
    .op1_i  (op1_i),
    .modrm_i(modrm_i),
    .cat_o  (dec_cat)
  );

  brtype_plm_adj u_plm_adj (
    .cat_i       (dec_cat),
    .src_kernel_i(src_kernel_i),
    .dst_kernel_i(dst_kernel_i),
    .src_zero_i  (src_zero_i),
    .dst_zero_i  (dst_zero_i),
    .mask_o      (next_mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      type_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) type_o <= next_mask;
    end
  end
endmodule

// File: rtl/brtype_classifier_chk.sv
module brtype_classifier_chk
  import brtype_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              src_kernel_i,
  input logic              dst_kernel_i,
  input logic              src_zero_i,
  input logic              dst_zero_i,
  input logic              valid_o,
  input logic [MASK_W-1:0] type_o
);
  a_r8_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(type_o)));
  a_r2_zero_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (src_zero_i || dst_zero_i)) |=> (type_o == '0));
  a_r6_crossing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !src_zero_i && !dst_zero_i && !src_kernel_i && dst_kernel_i)
      |=> (type_o[B_IRQ] || type_o[B_SYSCALL] || type_o[B_INT]));
  a_r7_target_plm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !src_zero_i && !dst_zero_i)
      |=> (type_o == '0 || (type_o[B_KERNEL] == $past(dst_kernel_i)
                             && $countones(type_o[B_KERNEL:B_USER]) == 1)));
  a_r9_one_category: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($countones(type_o[MASK_W-1:B_CALL]) <= 1));
endmodule

bind brtype_classifier brtype_classifier_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .src_kernel_i(src_kernel_i),
  .dst_kernel_i(dst_kernel_i),
  .src_zero_i  (src_zero_i),
  .dst_zero_i  (dst_zero_i),
  .valid_o     (valid_o),
  .type_o      (type_o)
);

// File: tb/brtype_classifier_bench.sv
module brtype_classifier_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  op0_i = '0, op1_i = '0, modrm_i = '0;
  logic        src_kernel_i = 1'b0, dst_kernel_i = 1'b0;
  logic        src_zero_i = 1'b0, dst_zero_i = 1'b0;
  logic        valid_o;
  logic [11:0] type_o;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk_i = ~clk_i;

  brtype_classifier u_brtype_classifier (.*);

  // expected category from the requirement tables (bit positions per R3..R6)
  function automatic logic [11:0] model(input logic [7:0] a, b, m,
                                        input logic sk, dk, sz, dz);
    logic [11:0] r;
    int x;
    r = 12'h000;
    x = int'(a);
    if (a == 8'h0F) begin
      if (b == 8'h05 || b == 8'h34) r = 12'h010;
      else if (b == 8'h07 || b == 8'h35) r = 12'h020;
      else if (b[7:4] == 4'h8) r = 12'h100;
    end else if (a == 8'hFF) begin
      if (m[5:4] == 2'b01) r = 12'h800;
      else if (m[5:4] == 2'b10) r = 12'h200;
    end else if ((x >= 'h70 && x <= 'h7F) || (x >= 'hE0 && x <= 'hE3)) r = 12'h100;
    else if (x == 'hC2 || x == 'hC3 || x == 'hCA || x == 'hCB) r = 12'h008;
    else if (x == 'hCF) r = 12'h080;
    else if (x >= 'hCC && x <= 'hCE) r = 12'h040;
    else if (x == 'hE8 || x == 'h9A) r = 12'h004;
    else if (x >= 'hE9 && x <= 'hEB) r = 12'h200;
    if (!sk && dk && r != 12'h010 && r != 12'h040) r = 12'h400;
    if (r != 0) r = r | (dk ? 12'h002 : 12'h001);
    if (sz || dz) r = 12'h000;
    return r;
  endfunction

  task automatic check(input string tag, input logic [11:0] act, exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %03h expected %03h (op %02h %02h modrm %02h sk%0b dk%0b)",
               tag, act, exp, op0_i, op1_i, modrm_i, src_kernel_i, dst_kernel_i);
    end
  endtask

  task automatic apply(input string tag, input logic [7:0] a, b, m,
                       input logic sk, dk, sz, dz);
    logic [11:0] e;
    @(negedge clk_i);
    op0_i = a; op1_i = b; modrm_i = m;
    src_kernel_i = sk; dst_kernel_i = dk; src_zero_i = sz; dst_zero_i = dz;
    valid_i = 1'b1;
    e = model(a, b, m, sk, dk, sz, dz);
    @(negedge clk_i);
    valid_i = 1'b0;
    check(tag, type_o, e);
    check("R8 valid", {11'd0, valid_o}, 12'h001);
    // R9: no more than one category bit
    check("R9 one category", ($countones(type_o[11:2]) <= 1) ? 12'h0 : 12'h1, 12'h0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] held;
    repeat (3) @(negedge clk_i);
    check("R1 reset type", type_o, 12'h000);
    check("R1 reset valid", {11'd0, valid_o}, 12'h000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after reset", type_o, 12'h000);

    for (int p = 0; p < 4; p++)
      for (int a = 0; a < 256; a++)
        apply("R4 single byte", 8'(a), 8'h00, 8'h00, p[1], p[0], 1'b0, 1'b0);
    for (int p = 0; p < 4; p++)
      for (int b = 0; b < 256; b++)
        apply("R3 escape", 8'h0F, 8'(b), 8'h00, p[1], p[0], 1'b0, 1'b0);
    for (int p = 0; p < 4; p++)
      for (int e = 0; e < 8; e++)
        for (int lo = 0; lo < 2; lo++)
          apply("R5 modrm ext", 8'hFF, 8'h00, {2'(lo * 3), 3'(e), 3'(lo * 5)},
                p[1], p[0], 1'b0, 1'b0);
    // R6 override on none, and kept for syscall / sw interrupt
    apply("R6 none to irq", 8'h90, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    apply("R6 syscall kept", 8'h0F, 8'h05, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    apply("R6 int kept", 8'hCD, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    apply("R7 user target", 8'hE8, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R7 none no plm", 8'h90, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
    // R2 zero addresses
    for (int z = 1; z < 4; z++)
      for (int p = 0; p < 4; p++) begin
        apply("R2 zero addr", 8'hC3, 8'h00, 8'h00, p[1], p[0], z[1], z[0]);
        apply("R2 zero addr", 8'h0F, 8'h05, 8'h00, p[1], p[0], z[1], z[0]);
        apply("R2 zero addr", 8'h90, 8'h00, 8'h00, p[1], p[0], z[1], z[0]);
      end
    // R8 hold while idle
    apply("R8 setup", 8'hCF, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
    held = type_o;
    op0_i = 8'hE8; src_kernel_i = 1'b0; dst_kernel_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R8 hold", type_o, held);
    check("R8 valid low", {11'd0, valid_o}, 12'h000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule